// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block maps local bus addresses that fall inside a fixed outbound region onto 64-bit PCIe bus addresses. The region is cut into a fixed number of equal windows placed back to back from the region base. All windows share one size, chosen by a 3-bit exponent: a window spans 2^(20+exponent) bytes. Each window holds its own 64-bit target base, made of a low word and a high word, and has its own enable flag. A single global enable in a command register turns translation on and off for the whole unit.

Software programs the unit through a simple word-wide register port. The datapath takes one local address per cycle with a valid strobe. One cycle later it returns a registered result: either a hit with the translated 64-bit address, or a miss with a zero address. A separate flag shows when the miss happened because translation was globally off.

Top module: `otw_xlate`

## Requirements
- R1: After a synchronous active-high reset, the command word, the size exponent and every window enable are zero. `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_xlate_off` and `reg_rdata` are also zero.
- R2: A read strobe returns data on `reg_rdata` on the following cycle, and `reg_rdata` is zero in cycles with no read. The register map is as follows.
  - Offset 0x004 is the 32-bit command word.
  - Offset 0x030 holds the size exponent in bits 2:0, and reads back zero-extended.
  - Offset 0x200+8·n is the low word of window n, and 0x204+8·n is its high word. Both read back as written.
  - Any other offset reads zero.
- R3: A write to the command word stores all 32 bits. Bit 1 alone is the global translation enable, so other bits can be changed without altering translation.
- R4: The window size is 2^(20+e) bytes for size exponent e. A request at address A selects window (A − REGION_BASE) >> (20+e).
- R5: On a hit, `rsp_addr` = {high word, low word with its low 20+e bits cleared} OR ((A − REGION_BASE) mod window size). Bit 0 of the low word and the other cleared bits never reach the result.
- R6: A request that selects a window whose low-word bit 0 (its enable) is 0 returns `rsp_miss`=1, `rsp_hit`=0 and `rsp_addr`=0.
- R7: A request below REGION_BASE, or one whose window number is NUM_WIN or more, returns a miss with a zero address.
- R8: While command bit 1 is 0, every request returns a miss with `rsp_xlate_off`=1. While command bit 1 is 1, `rsp_xlate_off` stays 0.
- R9: Each request cycle produces exactly one `rsp_valid` pulse on the next cycle. In that pulse exactly one of `rsp_hit` and `rsp_miss` is 1. All response flags are 0 when `rsp_valid` is 0.
- R10: A request in the same cycle as a register write is translated with the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No translation (disabled window, out of span, or global off) |
| rsp_xlate_off | output | 1 | Miss caused by the global enable being clear |
| rsp_addr | output | 64 | Translated address, zero on a miss |

## Verification
The bench sweeps all eight size exponents. For each one it probes every window at its first byte, its last byte and an interior point. First and last bytes show whether the window-number shift is right at each size. The interior point, together with low words that carry stray low bits, shows whether the base bits are masked correctly. A quarter of the windows are left disabled, so enable handling is checked in every window position. Addresses below the base and past the last window separate span checking from the enable lookup. A write issued in the same cycle as a request tells old-state from new-state lookup. A command word with the enable bit clear but other bits set checks that only bit 1 gates translation.

// File: rtl/otw_pkg.sv
package otw_pkg;
  // Minimum window size is 1 MiB
  localparam int MIB_SHIFT    = 20;
  localparam int SIZE_W       = 3;
  localparam int XLATE_EN_BIT = 1;
  // Register byte offsets; the window block stride is 8 bytes (low, high)
  localparam int CMD_OFS      = 'h004;
  localparam int SIZE_OFS     = 'h030;
  localparam int WIN_OFS      = 'h200;
  localparam int WIN_STRIDE_SH = 3;
endpackage

// File: rtl/otw_regs.sv
module otw_regs
  import otw_pkg::*;
#(
  parameter int NUM_WIN   = 32,
  parameter int DW        = 32,
  parameter int AW        = 12,
  parameter int WIN_IDX_W = $clog2(NUM_WIN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [WIN_IDX_W-1:0] lk_idx,
  output logic                 lk_en,
  output logic [DW-1:0]        lk_lo,
  output logic [DW-1:0]        lk_hi,
  output logic                 glob_en,
  output logic [SIZE_W-1:0]    size_idx
);
  localparam int WIN_SPAN = NUM_WIN << WIN_STRIDE_SH;

  logic [DW-1:0]     cmd_q;
  logic [SIZE_W-1:0] size_q;
  logic [NUM_WIN-1:0] en_q;
  // Offset words kept in reset-free arrays so they map to distributed RAM
  logic [DW-1:1] lo_mem [NUM_WIN];
  logic [DW-1:0] hi_mem [NUM_WIN];

  logic [AW-1:0]        rel;
  logic                 in_win;
  logic [WIN_IDX_W-1:0] a_idx;
  logic                 a_hi;
  logic [DW-1:0]        rd_val;

  assign rel    = reg_addr - AW'(WIN_OFS);
  assign in_win = (reg_addr >= AW'(WIN_OFS)) && (reg_addr < AW'(WIN_OFS + WIN_SPAN));
  assign a_idx  = rel[WIN_STRIDE_SH +: WIN_IDX_W];
  assign a_hi   = rel[2];

  always_ff @(posedge clk) begin
    if (reg_wr && in_win) begin
      if (a_hi) hi_mem[a_idx] <= reg_wdata;
      else      lo_mem[a_idx] <= reg_wdata[DW-1:1];
    end
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == AW'(CMD_OFS))       rd_val = cmd_q;
    else if (reg_addr == AW'(SIZE_OFS)) rd_val = DW'(size_q);
    else if (in_win)
      rd_val = a_hi ? hi_mem[a_idx] : {lo_mem[a_idx], en_q[a_idx]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      size_q    <= '0;
      en_q      <= '0;
      reg_rdata <= '0;
    end else begin
      reg_rdata <= reg_rd ? rd_val : '0;
      if (reg_wr) begin
        if (reg_addr == AW'(CMD_OFS))  cmd_q  <= reg_wdata;
        if (reg_addr == AW'(SIZE_OFS)) size_q <= reg_wdata[SIZE_W-1:0];
        if (in_win && !a_hi)           en_q[a_idx] <= reg_wdata[0];
      end
    end
  end

  assign lk_en    = en_q[lk_idx];
  assign lk_lo    = {lo_mem[lk_idx], 1'b0};
  assign lk_hi    = hi_mem[lk_idx];
  assign glob_en  = cmd_q[XLATE_EN_BIT];
  assign size_idx = size_q;
endmodule

// File: rtl/otw_index.sv
module otw_index
  import otw_pkg::*;
#(
  parameter int          NUM_WIN     = 32,
  parameter int          LA_W        = 32,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000,
  parameter int          WIN_IDX_W   = $clog2(NUM_WIN)
) (
  input  logic [LA_W-1:0]      addr,
  input  logic [SIZE_W-1:0]    size_idx,
  output logic [WIN_IDX_W-1:0] win_idx,
  output logic                 in_span,
  output logic [LA_W-1:0]      mask,
  output logic [LA_W-1:0]      ofs
);
  localparam int SH_W = $clog2(LA_W) + 1;

  logic [LA_W-1:0] diff;
  logic [LA_W-1:0] quo;
  logic [SH_W-1:0] sh;
  logic            below;

  always_comb begin
    diff    = addr - LA_W'(REGION_BASE);
    below   = addr < LA_W'(REGION_BASE);
    sh      = SH_W'(MIB_SHIFT) + SH_W'(size_idx);
    quo     = diff >> sh;
    mask    = ~({LA_W{1'b1}} << sh);
    in_span = !below && (quo < LA_W'(NUM_WIN));
    win_idx = quo[WIN_IDX_W-1:0];
    ofs     = diff & mask;
  end
endmodule

// File: rtl/otw_compose.sv
module otw_compose #(
  parameter int LA_W = 32,
  parameter int HI_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 glob_en,
  input  logic                 in_span,
  input  logic                 win_en,
  input  logic [LA_W-1:0]      lo,
  input  logic [HI_W-1:0]      hi,
  input  logic [LA_W-1:0]      mask,
  input  logic [LA_W-1:0]      ofs,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic                 rsp_miss,
  output logic                 rsp_off,
  output logic [HI_W+LA_W-1:0] rsp_addr
);
  logic hit_n;
  assign hit_n = glob_en && in_span && win_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_off   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit_n;
      rsp_miss  <= req_valid && !hit_n;
      rsp_off   <= req_valid && !glob_en;
      rsp_addr  <= (req_valid && hit_n) ? {hi, (lo & ~mask) | ofs} : '0;
    end
  end
endmodule

// File: rtl/otw_xlate.sv
module otw_xlate
  import otw_pkg::*;
#(
  parameter int          NUM_WIN     = 32,
  parameter int          DW          = 32,
  parameter int          RAW         = 12,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            req_valid,
  input  logic [DW-1:0]   req_addr,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic            rsp_xlate_off,
  output logic [2*DW-1:0] rsp_addr
);
  localparam int WIN_IDX_W = $clog2(NUM_WIN);

  logic [WIN_IDX_W-1:0] win_idx;
  logic                 in_span;
  logic [DW-1:0]        mask, ofs, lk_lo, lk_hi;
  logic                 lk_en, glob_en;
  logic [SIZE_W-1:0]    size_idx;

  otw_regs #(.NUM_WIN(NUM_WIN), .DW(DW), .AW(RAW), .WIN_IDX_W(WIN_IDX_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_idx(win_idx), .lk_en(lk_en),
    .lk_lo(lk_lo), .lk_hi(lk_hi), .glob_en(glob_en), .size_idx(size_idx)
  );

  otw_index #(.NUM_WIN(NUM_WIN), .LA_W(DW), .REGION_BASE(REGION_BASE),
              .WIN_IDX_W(WIN_IDX_W)) u_index (
    .addr(req_addr), .size_idx(size_idx), .win_idx(win_idx), .in_span(in_span),
    .mask(mask), .ofs(ofs)
  );

  otw_compose #(.LA_W(DW), .HI_W(DW)) u_compose (
    .clk(clk), .rst(rst), .req_valid(req_valid), .glob_en(glob_en), .in_span(in_span),
    .win_en(lk_en), .lo(lk_lo), .hi(lk_hi), .mask(mask), .ofs(ofs),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_off(rsp_xlate_off), .rsp_addr(rsp_addr)
  );
endmodule

// File: rtl/otw_xlate_chk.sv
module otw_xlate_chk
  import otw_pkg::*;
#(
  parameter int          DW          = 32,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [DW-1:0]   req_addr,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_xlate_off,
  input logic [2*DW-1:0] rsp_addr,
  input logic [DW-1:0]   reg_rdata
);
  logic [MIB_SHIFT-1:0] rel_lo;
  assign rel_lo = MIB_SHIFT'(req_addr - DW'(REGION_BASE));

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && reg_rdata == '0));

  p_one_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss}) == 1));

  p_idle_flags_r9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_xlate_off));

  p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_addr == '0));

  p_off_is_miss_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_xlate_off |-> rsp_miss);

  p_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid ##1 rsp_hit) |-> (rsp_addr[MIB_SHIFT-1:0] == $past(rel_lo)));
endmodule

bind otw_xlate otw_xlate_chk #(.DW(DW), .REGION_BASE(REGION_BASE)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_xlate_off(rsp_xlate_off), .rsp_addr(rsp_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_otw_xlate.sv
module test_otw_xlate;
  localparam int          CLK_PERIOD = 10;
  localparam int          NW         = 32;
  localparam logic [31:0] BASE       = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_xlate_off;
  logic [63:0] rsp_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  otw_xlate #(.NUM_WIN(NW), .REGION_BASE(BASE)) i_otw_xlate (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_xlate_off(rsp_xlate_off), .rsp_addr(rsp_addr)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_lo [NW];
  logic [31:0] m_hi [NW];
  logic [31:0] m_cmd = '0;
  int          m_sz = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [65:0] expect_of(input logic [31:0] a);
    logic [31:0] diff, mask, wi;
    int sh;
    bit hit;
    logic [63:0] ea;
    diff = a - BASE;
    sh   = 20 + m_sz;
    mask = (32'h1 << sh) - 32'h1;
    wi   = diff >> sh;
    hit  = m_cmd[1] && (a >= BASE) && (wi < NW) && m_lo[wi[4:0]][0];
    ea   = hit ? {m_hi[wi[4:0]], (m_lo[wi[4:0]] & ~mask) | (diff & mask)} : 64'h0;
    return {hit, !m_cmd[1], ea};
  endfunction

  task automatic check_rsp(input logic [65:0] e, input string rq);
    chk(rsp_valid === 1'b1, "R9 valid", {63'h0, rsp_valid}, 64'h1);
    chk(rsp_hit === e[65] && rsp_miss === !e[65], rq, {62'h0, rsp_hit, rsp_miss},
        {62'h0, e[65], !e[65]});
    chk(rsp_xlate_off === e[64], "R8 off flag", {63'h0, rsp_xlate_off}, {63'h0, e[64]});
    chk(rsp_addr === e[63:0], rq, rsp_addr, e[63:0]);
  endtask

  task automatic req_chk(input logic [31:0] a, input string rq);
    logic [65:0] e;
    e = expect_of(a);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    check_rsp(e, rq);
    @(negedge clk);
    chk(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_xlate_off, "R9 single pulse",
        {60'h0, rsp_valid, rsp_hit, rsp_miss, rsp_xlate_off}, 64'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R9: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] ws;
    logic [65:0] e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_xlate_off, "R1 rsp flags",
        {60'h0, rsp_valid, rsp_hit, rsp_miss, rsp_xlate_off}, 64'h0);
    chk(reg_rdata == 32'h0, "R1 rdata", {32'h0, reg_rdata}, 64'h0);
    rd(12'h004, d); chk(d == 32'h0, "R1 cmd", {32'h0, d}, 64'h0);
    rd(12'h030, d); chk(d == 32'h0, "R1 size", {32'h0, d}, 64'h0);
    for (int w = 0; w < NW; w++) begin
      rd(12'(12'h200 + 8*w), d);
      chk(d[0] == 1'b0, "R1 window enable", {63'h0, d[0]}, 64'h0);
    end

    // Program windows: low words carry stray low bits to test masking (R5)
    for (int w = 0; w < NW; w++) begin
      m_lo[w] = (32'h9E37_79B9 * 32'(w + 1)) & 32'hFFFF_FFFE;
      m_lo[w][0] = (w % 4 != 3);
      m_hi[w] = 32'h1000_0000 + 32'(w) * 32'h0101;
      wr(12'(12'h200 + 8*w), m_lo[w]);
      wr(12'(12'h204 + 8*w), m_hi[w]);
    end
    for (int w = 0; w < NW; w++) begin
      rd(12'(12'h200 + 8*w), d); chk(d == m_lo[w], "R2 low word", {32'h0, d}, {32'h0, m_lo[w]});
      rd(12'(12'h204 + 8*w), d); chk(d == m_hi[w], "R2 high word", {32'h0, d}, {32'h0, m_hi[w]});
    end
    rd(12'h100, d); chk(d == 32'h0, "R2 unmapped", {32'h0, d}, 64'h0);
    rd(12'h300, d); chk(d == 32'h0, "R2 past windows", {32'h0, d}, 64'h0);

    // R3/R8: other command bits set, enable clear -> translation off
    m_cmd = 32'hA5A5_0001;
    wr(12'h004, m_cmd);
    rd(12'h004, d); chk(d == m_cmd, "R3 cmd readback", {32'h0, d}, {32'h0, m_cmd});
    req_chk(BASE + 32'h10, "R8 global off");

    m_cmd = 32'hA5A5_0003;
    wr(12'h004, m_cmd);
    rd(12'h004, d); chk(d == m_cmd, "R3 cmd readback", {32'h0, d}, {32'h0, m_cmd});

    // Sweep every size exponent over every window
    for (int sz = 0; sz < 8; sz++) begin
      m_sz = sz;
      wr(12'h030, 32'hFFFF_FFF8 | 32'(sz));
      rd(12'h030, d); chk(d == 32'(sz), "R2 size readback", {32'h0, d}, 64'(sz));
      ws = 32'h1 << (20 + sz);
      for (int w = 0; w < NW; w++) begin
        req_chk(BASE + 32'(w) * ws, (w % 4 != 3) ? "R4 window start" : "R6 disabled");
        req_chk(BASE + 32'(w + 1) * ws - 32'h1, (w % 4 != 3) ? "R4 window end" : "R6 disabled");
        req_chk(BASE + 32'(w) * ws + (ws >> 1) + 32'h1234, (w % 4 != 3) ? "R5 interior" : "R6 disabled");
      end
      req_chk(BASE - 32'h1, "R7 below base");
      req_chk(32'h0, "R7 below base");
      if (sz <= 5) req_chk(BASE + 32'(NW) * ws, "R7 past span");
    end

    // R10: same-cycle write of window 5 enable-off and request to window 5
    m_sz = 0;
    wr(12'h030, 32'h0);
    e = expect_of(BASE + 32'h0050_0010);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h228; reg_wdata = m_lo[5] & 32'hFFFF_FFFE;
    req_valid = 1'b1; req_addr = BASE + 32'h0050_0010;
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b0;
    check_rsp(e, "R10 old state used");
    m_lo[5] = m_lo[5] & 32'hFFFF_FFFE;
    req_chk(BASE + 32'h0050_0010, "R10 new state after write R6");

    // R8: clear global enable again
    m_cmd = 32'h0000_00FD;
    wr(12'h004, m_cmd);
    req_chk(BASE + 32'h0010_0000, "R8 global off");

    done = 1;
    summary();
    $finish;
  end
endmodule